// File: doc/BRIEF.md
# Third-Order Cascaded Sigma-Delta Divide-Ratio Modulator

This block produces the instantaneous divide value for a fractional-N frequency divider. It runs on the divider output clock. On every cycle it adds a small signed offset to an integer base ratio, so that the average divide value equals the base ratio plus a fractional word scaled by the full accumulator range.

Three first-order accumulators are chained. The first adds the fractional word to its stored residue. Each later accumulator adds the fresh residue of the stage before it. Each stage raises a carry in any cycle where its sum wraps past the full scale. The three carries are then combined through first and second differences into an offset from -3 to +4. This cancels the quantization error of the first two stages and shapes what is left toward high frequencies. Because every stage is first order, the cascade is stable for every input word.

Top module: `mash3_divctl`

## Requirements
- R1: While `rst_n` is low, all residues, carries and carry delay registers are zero, and `div_value` equals `int_n` and follows it combinationally.
- R2: On each rising clock edge with reset released, the first residue becomes (residue + `frac_word`) modulo 2^FRAC_W. Its carry is set for that cycle exactly when the unreduced sum reaches 2^FRAC_W.
- R3: The second and third stages use the same update rule. Each takes as its input the new residue of the stage before it in the same edge, and never that stage's carry.
- R4: `div_value` = `int_n` + c1 + c2 − c2' + c3 − 2·c3' + c3'', taken modulo 2^INT_W. Here ck is the carry registered at the last edge, ' means one edge earlier and '' means two edges earlier; each delayed term reads as zero before it has been registered.
- R5: The signed offset `div_value` − `int_n` always lies in the range −3 to +4.
- R6: Over 2·2^FRAC_W cycles after reset with a constant word F, the offsets sum to a value between 2F−1 and 2F+2.
- R7: With `frac_word` = 0 from reset, `div_value` stays equal to `int_n` on every cycle.
- R8: A change of `int_n` appears in `div_value` in the same cycle and does not disturb the accumulator or delay state.
- R9: The largest word, 2^FRAC_W−1, is accepted and meets R4 through R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider output clock; one modulator step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of all stage state |
| frac_word | input | FRAC_W | Fractional control word, unsigned |
| int_n | input | INT_W | Integer base divide ratio |
| div_value | output | INT_W | Instantaneous divide ratio, base plus signed offset |

## Verification
The assertions check, on every cycle, that each stage's carry agrees with its wrap condition relative to its own input, that the later stages only wrap below the residue they were fed, that the offset stays within −3 to +4, that a zero word with cleared state stays cleared, and that reset holds the offset at zero. The exact sequence of divide values, the long-run average that proves the delays are aligned, and the immediate take-up of a new base ratio in the middle of a run can only be shown by the bench. It does this by running an independent arithmetic model over whole accumulator periods for several words.

// File: rtl/mash_pkg.sv
package mash_pkg;

  localparam int MASH_ORDER = 3;
  localparam int OFS_W      = 4;

  typedef logic signed [OFS_W-1:0] ofs_t;

  // weighted sum of present and delayed carries: first stage direct,
  // second stage first difference, third stage second difference
  function automatic ofs_t mash3_offset(input logic c1, input logic c2,
                                        input logic c2_d1, input logic c3,
                                        input logic c3_d1, input logic c3_d2);
    int acc;
    acc = int'(c1) + int'(c2) - int'(c2_d1)
        + int'(c3) - 2 * int'(c3_d1) + int'(c3_d2);
    return ofs_t'(acc);
  endfunction

  // sign-extend the offset and add it to the base ratio, wrapping
  function automatic logic [31:0] apply_offset(input logic [31:0] base,
                                               input ofs_t ofs);
    logic [31:0] ext;
    ext = {{(32-OFS_W){ofs[OFS_W-1]}}, ofs};
    return base + ext;
  endfunction

endpackage

// File: rtl/mash_stage.sv
module mash_stage #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] in_val,
  output logic [ACC_W-1:0] sum_next,
  output logic [ACC_W-1:0] sum_q,
  output logic             carry_q
);

  logic [ACC_W:0] total;

  assign total    = {1'b0, in_val} + {1'b0, sum_q};
  assign sum_next = total[ACC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      sum_q   <= total[ACC_W-1:0];
      carry_q <= total[ACC_W];
    end
  end

endmodule

// File: rtl/mash_recombine.sv
module mash_recombine
  import mash_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MASH_ORDER-1:0] carry,
  output logic                  c2_d1,
  output logic                  c3_d1,
  output logic                  c3_d2,
  output ofs_t                  offset
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_d1 <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else begin
      c2_d1 <= carry[1];
      c3_d1 <= carry[2];
      c3_d2 <= c3_d1;
    end
  end

  assign offset = mash3_offset(carry[0], carry[1], c2_d1,
                               carry[2], c3_d1, c3_d2);

endmodule

// File: rtl/mash3_divctl.sv
module mash3_divctl
  import mash_pkg::*;
#(
  parameter int FRAC_W = 16,
  parameter int INT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] frac_word,
  input  logic [INT_W-1:0]  int_n,
  output logic [INT_W-1:0]  div_value
);

  logic [FRAC_W-1:0]     stage_in   [MASH_ORDER];
  logic [FRAC_W-1:0]     stage_next [MASH_ORDER];
  logic [FRAC_W-1:0]     stage_sum  [MASH_ORDER];
  logic [MASH_ORDER-1:0] stage_carry;

  // named internal events for the checker
  logic [FRAC_W-1:0] s1_q, s2_q, s3_q;
  logic              c1_q, c2_q, c3_q;
  logic              c2_dly, c3_dly, c3_dly2;
  ofs_t              offset_w;
  logic [31:0]       div_full;

  genvar k;
  generate
    for (k = 0; k < MASH_ORDER; k++) begin : g_stage
      if (k == 0) begin : g_head
        assign stage_in[k] = frac_word;
      end else begin : g_chain
        assign stage_in[k] = stage_next[k-1];
      end
      mash_stage #(.ACC_W(FRAC_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_val   (stage_in[k]),
        .sum_next (stage_next[k]),
        .sum_q    (stage_sum[k]),
        .carry_q  (stage_carry[k])
      );
    end
  endgenerate

  mash_recombine u_recombine (
    .clk    (clk),
    .rst_n  (rst_n),
    .carry  (stage_carry),
    .c2_d1  (c2_dly),
    .c3_d1  (c3_dly),
    .c3_d2  (c3_dly2),
    .offset (offset_w)
  );

  assign s1_q = stage_sum[0];
  assign s2_q = stage_sum[1];
  assign s3_q = stage_sum[2];
  assign c1_q = stage_carry[0];
  assign c2_q = stage_carry[1];
  assign c3_q = stage_carry[2];

  assign div_full  = apply_offset(32'(int_n), offset_w);
  assign div_value = div_full[INT_W-1:0];

endmodule

// File: rtl/mash3_divctl_chk.sv
module mash3_divctl_chk
  import mash_pkg::*;
#(
  parameter int FRAC_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FRAC_W-1:0] frac_word,
  input logic [FRAC_W-1:0] s1_q,
  input logic [FRAC_W-1:0] s2_q,
  input logic [FRAC_W-1:0] s3_q,
  input logic              c1_q,
  input logic              c2_q,
  input logic              c3_q,
  input ofs_t              offset_w
);

  logic run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  // R2
  stage1_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n || !run_q)
    c1_q |-> (s1_q < $past(frac_word)));

  // R2
  stage1_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n || !run_q)
    !c1_q |-> (s1_q >= $past(frac_word)));

  // R3
  stage2_residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c2_q |-> (s2_q < s1_q));

  // R3
  stage3_residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c3_q |-> (s3_q < s2_q));

  // R5
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offset_w >= -4'sd3) && (offset_w <= 4'sd4));

  // R7
  zero_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_word == '0 && s1_q == '0 && s2_q == '0 && s3_q == '0 && !c1_q && !c2_q && !c3_q)
      |=> (!c1_q && !c2_q && !c3_q && s1_q == '0));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (offset_w == 4'sd0 && !c1_q && s1_q == '0));

endmodule

bind mash3_divctl mash3_divctl_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frac_word (frac_word),
  .s1_q      (s1_q),
  .s2_q      (s2_q),
  .s3_q      (s3_q),
  .c1_q      (c1_q),
  .c2_q      (c2_q),
  .c3_q      (c3_q),
  .offset_w  (offset_w)
);

// File: tb/test_mash3_divctl.sv
`timescale 1ns/1ps
module test_mash3_divctl;

  localparam int FW = 10;
  localparam int IW = 8;
  localparam int FS = 1 << FW;
  localparam int MS = 1 << IW;
  localparam int RUN = 2 * FS;
  localparam int NVEC = 6;

  // {frac_word[17:8], int_n[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {10'd1,    8'd90},
    {10'd512,  8'd40},
    {10'd1023, 8'd200},
    {10'd341,  8'd3},
    {10'd0,    8'd100},
    {10'd777,  8'd251}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [FW-1:0] frac_word = '0;
  logic [IW-1:0] int_n = '0;
  logic [IW-1:0] div_value;

  int checks = 0;
  int errors = 0;

  // independent model state
  int m_s1, m_s2, m_s3, m_c1, m_c2, m_c3, m_c2p, m_c3p, m_c3pp;

  always #4 clk = ~clk;

  mash3_divctl #(.FRAC_W(FW), .INT_W(IW)) i_mash3_divctl (
    .clk(clk), .rst_n(rst_n), .frac_word(frac_word),
    .int_n(int_n), .div_value(div_value)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_s1 = 0; m_s2 = 0; m_s3 = 0;
    m_c1 = 0; m_c2 = 0; m_c3 = 0;
    m_c2p = 0; m_c3p = 0; m_c3pp = 0;
  endtask

  task automatic model_step(input int f);
    int t1, t2, t3;
    t1 = m_s1 + f;  t2 = m_s2 + (t1 % FS);  t3 = m_s3 + (t2 % FS);
    m_c3pp = m_c3p; m_c3p = m_c3; m_c2p = m_c2;
    m_c1 = (t1 >= FS) ? 1 : 0;
    m_c2 = (t2 >= FS) ? 1 : 0;
    m_c3 = (t3 >= FS) ? 1 : 0;
    m_s1 = t1 % FS; m_s2 = t2 % FS; m_s3 = t3 % FS;
  endtask

  function automatic int model_ofs();
    return m_c1 + m_c2 - m_c2p + m_c3 - 2 * m_c3p + m_c3pp;
  endfunction

  function automatic int wrap_out(input int n, input int o);
    return (n + o + MS) % MS;
  endfunction

  function automatic int seen_ofs(input int outv, input int n);
    int d;
    d = (outv - n + MS) % MS;
    return (d > MS / 2) ? d - MS : d;
  endfunction

  task automatic do_reset(input int f, input int n);
    @(negedge clk);
    rst_n = 1'b0;
    frac_word = FW'(f);
    int_n = IW'(n);
    model_clear();
    #1;
    // R1: output equals base ratio under reset
    check(int'(div_value) == n, "R1 reset output", int'(div_value), n);
    int_n = IW'((n + 7) % MS);
    #1;
    check(int'(div_value) == (n + 7) % MS, "R1 follows int_n in reset", int'(div_value), (n + 7) % MS);
    int_n = IW'(n);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // run cycles comparing with model; returns offset sum and extremes
  task automatic run_cycles(input int cyc, input int f, input int n,
                            output int sum_o, output int lo, output int hi);
    int exp_v, so;
    sum_o = 0; lo = 99; hi = -99;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk);
      model_step(f);
      @(negedge clk);
      exp_v = wrap_out(n, model_ofs());
      // R2 R3 R4: per-cycle divide value
      check(int'(div_value) == exp_v, "R2 R3 R4 divide value", int'(div_value), exp_v);
      so = seen_ofs(int'(div_value), n);
      sum_o += so;
      if (so < lo) lo = so;
      if (so > hi) hi = so;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int f, n, s, lo, hi, exp_v;
    // table-driven runs
    for (int v = 0; v < NVEC; v++) begin
      f = int'(VEC[v][17:8]);
      n = int'(VEC[v][7:0]);
      do_reset(f, n);
      run_cycles(RUN, f, n, s, lo, hi);
      // R5
      check(lo >= -3, "R5 offset low bound", lo, -3);
      check(hi <= 4, "R5 offset high bound", hi, 4);
      // R6 R9: long-run average
      check(s >= 2 * f - 1 && s <= 2 * f + 2, "R6 R9 offset sum", s, 2 * f);
      if (f == 0) begin
        // R7
        check(lo == 0 && hi == 0, "R7 zero word holds base", hi - lo, 0);
      end
    end

    // R8: base ratio change mid-run
    do_reset(341, 60);
    run_cycles(500, 341, 60, s, lo, hi);
    int_n = IW'(61);
    #1;
    exp_v = wrap_out(61, model_ofs());
    check(int'(div_value) == exp_v, "R8 same-cycle base change", int'(div_value), exp_v);
    run_cycles(200, 341, 61, s, lo, hi);

    // R2 R3: word change mid-run, state carried over
    frac_word = FW'(900);
    run_cycles(RUN, 900, 61, s, lo, hi);
    check(lo >= -3 && hi <= 4, "R5 after word change", hi, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule